// File: doc/BRIEF.md
# Frame-Sync Mode Detector for a Multiplexed Serial Port

This block sits on the receive side of a serial port that carries either plain stereo audio or time-division-multiplexed command and audio traffic. The same frame-sync and bit-clock wires are used in both cases. The block tells the two apart by measuring how long frame sync stays high, counted in bit clocks. A frame whose sync pulse is exactly two bit clocks wide is a multiplexed frame. A frame sync with a half-period high time is ordinary stereo framing and never qualifies.

Frame sync is sampled on every rising bit-clock edge. Each rising edge of the sampled sync starts a new frame and raises a one-cycle strobe. The block measures the width of the high pulse and judges the frame when sync falls. Multiplexed mode is declared only after two back-to-back qualifying frames. Command acceptance then opens at the start of the next frame, so the frame in which the mode was declared never carries accepted commands. Any frame of another width closes the mode again.

Top module: `tdm_frame_detector`

## Requirements
- R1: `frame_start` is high for exactly one cycle, in the cycle after the bit-clock edge that first samples `fsync` high following a low sample.
- R2: The pulse width of a frame is the number of consecutive bit-clock edges that sample `fsync` high. A frame qualifies only when this number is exactly 2. Widths of 1 or 3 do not qualify.
- R3: Frames whose high time is not 2 samples, including half-duty stereo framing, never set `tdm_mode`.
- R4: `tdm_mode` rises once two consecutive frames qualify. It is high in the second cycle after the edge that first samples `fsync` low in the second such frame.
- R5: A non-qualifying frame resets the qualifying-frame run. A qualifying frame, then a non-qualifying one, then a qualifying one leaves `tdm_mode` low.
- R6: `cmd_accept` stays low during the frame in which `tdm_mode` was set. It rises in the cycle after the `frame_start` strobe of the next frame, provided `tdm_mode` is still high.
- R7: While `tdm_mode` is high, a non-qualifying frame drops both `tdm_mode` and `cmd_accept`.
- R8: The width counter saturates at its maximum. A high time longer than the counter range, such as 258 samples with an 8-bit counter, never qualifies.
- R9: When `rst_n` is low at a rising bit-clock edge, all outputs and internal history clear. The sampled frame sync counts as low afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fsync | input | 1 | Frame-sync line, one period per audio frame |
| frame_start | output | 1 | One-cycle strobe at each detected frame start |
| tdm_mode | output | 1 | High while multiplexed framing is recognised |
| cmd_accept | output | 1 | High while command fields may be accepted |

## Verification
A wrong width count or a wrong edge history shows first in `tdm_mode`, two cycles after the falling sync sample that ends the frame. A corrupted qualifying-frame run shows as a mode that rises one frame too early or too late. A stale command enable shows in the cycle after the next `frame_start` strobe. Every error therefore surfaces within one frame of its cause. The bench checks the outputs at each frame start and again at each frame end.

// File: rtl/tdm_det_pkg.sv
// Package: shared types for the frame-sync mode detector.
// Assumes: nothing beyond a single bit-clock domain.
package tdm_det_pkg;

    // Outcome of one frame, valid for a single cycle when sync falls.
    typedef struct packed {
        logic valid;    // a frame has just ended
        logic qualify;  // its high time matched the multiplexed width
    } frame_verdict_t;

endpackage

// File: rtl/fsync_edges.sv
// Module: fsync_edges
// Samples the frame-sync line on each rising bit-clock edge and keeps one
// older sample, so rising and falling transitions are found from flops only.
// Assumes: fsync is already synchronous to bclk (the bus shares one clock).
module fsync_edges (
    input  logic bclk,
    input  logic rst_n,
    input  logic fsync,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);

    logic smp_now;
    logic smp_old;

    // Purpose: two-deep history of the sampled frame sync.
    always_ff @(posedge bclk) begin
        if (!rst_n) begin
            smp_now <= 1'b0;
            smp_old <= 1'b0;
        end else begin
            smp_now <= fsync;
            smp_old <= smp_now;
        end
    end

    // Purpose: transition decode from the two stored samples.
    always_comb begin
        level_o = smp_now;
        rise_o  = smp_now & ~smp_old;
        fall_o  = ~smp_now & smp_old;
    end

    AST_STROBE_ONE_CYCLE: assert property (@(posedge bclk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R1

    AST_RISE_FALL_EXCLUSIVE: assert property (@(posedge bclk) disable iff (!rst_n)
        !(rise_o && fall_o)); // R1

endmodule

// File: rtl/pulse_meter.sv
// Module: pulse_meter
// Counts the sampled high cycles of frame sync and judges each frame when
// sync falls: the frame qualifies when the count equals TARGET_W.
// Assumes: rise_i, fall_i and level_i come from fsync_edges. The counter
// saturates, so a long high time can never wrap around to TARGET_W.
module pulse_meter
    import tdm_det_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int TARGET_W = 2
) (
    input  logic           bclk,
    input  logic           rst_n,
    input  logic           level_i,
    input  logic           rise_i,
    input  logic           fall_i,
    output frame_verdict_t verdict_o
);

    localparam logic [CNT_W-1:0] CNT_MAX    = '1;
    localparam logic [CNT_W-1:0] CNT_TARGET = CNT_W'(TARGET_W);
    localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);

    logic [CNT_W-1:0] width_cnt;

    // Purpose: restart on a frame start, then count high samples up to saturation.
    always_ff @(posedge bclk) begin
        if (!rst_n) begin
            width_cnt <= '0;
        end else if (rise_i) begin
            width_cnt <= CNT_ONE;
        end else if (level_i && (width_cnt != CNT_MAX)) begin
            width_cnt <= width_cnt + CNT_ONE;
        end
    end

    // Purpose: frame judgement, presented in the cycle where sync is seen low.
    always_comb begin
        verdict_o.valid   = fall_i;
        verdict_o.qualify = fall_i && (width_cnt == CNT_TARGET);
    end

    AST_CNT_SATURATES: assert property (@(posedge bclk) disable iff (!rst_n)
        (width_cnt == CNT_MAX && level_i && !rise_i) |=> (width_cnt == CNT_MAX)); // R8

    AST_RISE_RESTARTS: assert property (@(posedge bclk) disable iff (!rst_n)
        rise_i |=> (width_cnt == CNT_ONE)); // R2

    AST_CNT_HELD_LOW: assert property (@(posedge bclk) disable iff (!rst_n)
        (!level_i && !rise_i) |=> $stable(width_cnt)); // R2

endmodule

// File: rtl/mode_ctrl.sv
// Module: mode_ctrl
// Counts back-to-back qualifying frames, declares the multiplexed mode after
// ENTRY_FRAMES of them, and opens command acceptance at the next frame start.
// Assumes: a verdict and a frame start never occur in the same cycle.
module mode_ctrl
    import tdm_det_pkg::*;
#(
    parameter int ENTRY_FRAMES = 2
) (
    input  logic           bclk,
    input  logic           rst_n,
    input  frame_verdict_t verdict_i,
    input  logic           rise_i,
    output logic           mode_o,
    output logic           cmd_en_o
);

    localparam int            RUN_W   = $clog2(ENTRY_FRAMES + 1);
    localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(ENTRY_FRAMES);
    localparam logic [RUN_W-1:0] RUN_ONE  = RUN_W'(1);

    logic [RUN_W-1:0] run_cnt;
    logic [RUN_W-1:0] run_next;
    logic             entry_hit;

    // Purpose: saturating successor of the qualifying-frame run.
    always_comb begin
        run_next  = (run_cnt == RUN_FULL) ? run_cnt : run_cnt + RUN_ONE;
        entry_hit = (run_next == RUN_FULL);
    end

    // Purpose: run counter, mode flag and command enable updates.
    always_ff @(posedge bclk) begin
        if (!rst_n) begin
            run_cnt  <= '0;
            mode_o   <= 1'b0;
            cmd_en_o <= 1'b0;
        end else if (verdict_i.valid) begin
            if (verdict_i.qualify) begin
                run_cnt <= run_next;
                if (entry_hit) begin
                    mode_o <= 1'b1;
                end
            end else begin
                run_cnt  <= '0;
                mode_o   <= 1'b0;
                cmd_en_o <= 1'b0;
            end
        end else if (rise_i && mode_o) begin
            cmd_en_o <= 1'b1;
        end
    end

    AST_MODE_NEEDS_QUALIFY: assert property (@(posedge bclk) disable iff (!rst_n)
        $rose(mode_o) |-> $past(verdict_i.valid && verdict_i.qualify)); // R4

    AST_NO_CMD_ON_ENTRY: assert property (@(posedge bclk) disable iff (!rst_n)
        $rose(mode_o) |-> !cmd_en_o); // R6

    AST_CMD_NEEDS_MODE: assert property (@(posedge bclk) disable iff (!rst_n)
        cmd_en_o |-> mode_o); // R6

    AST_BAD_FRAME_CLEARS: assert property (@(posedge bclk) disable iff (!rst_n)
        (verdict_i.valid && !verdict_i.qualify) |=> (!mode_o && !cmd_en_o)); // R7

    AST_RUN_BOUNDED: assert property (@(posedge bclk) disable iff (!rst_n)
        run_cnt <= RUN_FULL); // R5

endmodule

// File: rtl/tdm_frame_detector.sv
// Module: tdm_frame_detector (top)
// Decides whether a serial port runs multiplexed command/audio framing, based
// on the width of the frame-sync high pulse measured in bit clocks.
// Assumes: fsync and bclk are shared by every device on the bus. There is one
// frame per sync period, and the reset is synchronous and active low.
module tdm_frame_detector
    import tdm_det_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int TARGET_W     = 2,
    parameter int ENTRY_FRAMES = 2
) (
    input  logic bclk,
    input  logic rst_n,
    input  logic fsync,
    output logic frame_start,
    output logic tdm_mode,
    output logic cmd_accept
);

    logic           sync_level;
    logic           sync_rise;
    logic           sync_fall;
    frame_verdict_t verdict;

    fsync_edges u_edges (
        .bclk    (bclk),
        .rst_n   (rst_n),
        .fsync   (fsync),
        .level_o (sync_level),
        .rise_o  (sync_rise),
        .fall_o  (sync_fall)
    );

    pulse_meter #(
        .CNT_W    (CNT_W),
        .TARGET_W (TARGET_W)
    ) u_meter (
        .bclk      (bclk),
        .rst_n     (rst_n),
        .level_i   (sync_level),
        .rise_i    (sync_rise),
        .fall_i    (sync_fall),
        .verdict_o (verdict)
    );

    mode_ctrl #(
        .ENTRY_FRAMES (ENTRY_FRAMES)
    ) u_mode (
        .bclk      (bclk),
        .rst_n     (rst_n),
        .verdict_i (verdict),
        .rise_i    (sync_rise),
        .mode_o    (tdm_mode),
        .cmd_en_o  (cmd_accept)
    );

    // Purpose: the frame-start strobe is the decoded rising transition.
    always_comb frame_start = sync_rise;

    AST_RESET_CLEARS: assert property (@(posedge bclk)
        !rst_n |=> (!frame_start && !tdm_mode && !cmd_accept)); // R9

endmodule

// File: tb/tb_tdm_frame_detector.sv
module tb_tdm_frame_detector;

    logic bclk = 1'b0;
    logic rst_n = 1'b0;
    logic fsync = 1'b0;
    logic frame_start, tdm_mode, cmd_accept;

    int checks = 0;
    int errors = 0;

    // reference state kept at frame level
    int m_run  = 0;
    bit m_mode = 1'b0;
    bit m_cen  = 1'b0;

    always #2 bclk = ~bclk;

    tdm_frame_detector dut (
        .bclk(bclk), .rst_n(rst_n), .fsync(fsync),
        .frame_start(frame_start), .tdm_mode(tdm_mode), .cmd_accept(cmd_accept)
    );

    task automatic chk(input bit got, input bit exp, input string tag, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, got, exp);
        end
    endtask

    // expected values at the end of a frame of `hi` high samples
    function automatic bit exp_mode_after(int hi, int run, bit mode);
        if (hi != 2) return 1'b0;
        return mode || ((run + 1) >= 2);
    endfunction

    function automatic bit exp_cen_after(int hi, bit cen, bit mode);
        if (hi != 2) return 1'b0;
        return cen || mode;
    endfunction

    // one frame: hi high samples then lo low samples (lo >= 2), plus an observe cycle
    task automatic run_frame(input int hi, input int lo, input string tag);
        bit mid_cen;
        bit end_mode;
        bit end_cen;
        mid_cen  = m_cen || m_mode;
        end_mode = exp_mode_after(hi, m_run, m_mode);
        end_cen  = exp_cen_after(hi, m_cen, m_mode);
        for (int i = 0; i < hi + lo; i++) begin
            @(negedge bclk);
            if (i == 1) chk(frame_start, 1'b1, "R1", "strobe after rise");
            if (i == 2) begin
                chk(frame_start, 1'b0, "R1", "strobe one cycle");
                chk(cmd_accept, mid_cen, "R6", "enable after frame start");
            end
            fsync = (i < hi);
        end
        @(negedge bclk);
        chk(tdm_mode, end_mode, tag, "mode at frame end");
        chk(cmd_accept, end_cen, tag, "enable at frame end");
        if (hi == 2) m_run = (m_run >= 2) ? 2 : m_run + 1;
        else m_run = 0;
        m_mode = end_mode;
        m_cen  = end_cen;
    endtask

    task automatic do_reset(input int cycles, input string tag);
        @(negedge bclk);
        rst_n = 1'b0;
        fsync = 1'b0;
        repeat (cycles) @(negedge bclk);
        chk(frame_start, 1'b0, tag, "strobe in reset");
        chk(tdm_mode, 1'b0, tag, "mode in reset");
        chk(cmd_accept, 1'b0, tag, "enable in reset");
        rst_n = 1'b1;
        m_run = 0;
        m_mode = 1'b0;
        m_cen = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset(4, "R9");

        // R3: half-duty stereo framing never enters the mode
        repeat (4) run_frame(16, 16, "R3");
        // R2: widths 1 and 3 rejected around a qualifying frame
        run_frame(1, 5, "R2");
        run_frame(2, 6, "R2");
        run_frame(3, 5, "R2");
        // R5: qualify, break, qualify leaves mode low
        run_frame(2, 4, "R5");
        run_frame(5, 4, "R5");
        run_frame(2, 4, "R5");
        // R4: second consecutive qualifying frame sets the mode, R6 enable next frame
        run_frame(2, 4, "R4");
        run_frame(2, 4, "R6");
        run_frame(2, 3, "R6");
        // R7: bad frame drops mode and enable
        run_frame(16, 16, "R7");
        // R8: re-enter, then an over-range pulse must not wrap to a match
        run_frame(2, 2, "R4");
        run_frame(2, 2, "R4");
        run_frame(2, 2, "R6");
        run_frame(258, 4, "R8");
        run_frame(2, 3, "R8");
        // R9: reset while in the mode
        run_frame(2, 3, "R4");
        run_frame(2, 3, "R4");
        run_frame(2, 3, "R6");
        do_reset(2, "R9");
        run_frame(2, 3, "R9");

        // random mix
        for (int n = 0; n < 200; n++) begin
            int sel;
            int hi;
            int lo;
            sel = int'($urandom % 5);
            lo  = 2 + int'($urandom % 30);
            case (sel)
                0, 1: hi = 2;
                2: hi = 1 + int'($urandom % 40);
                3: hi = ($urandom % 2) ? 1 : 3;
                default: begin hi = 12; lo = 12; end
            endcase
            run_frame(hi, lo, (hi == 2) ? "R4" : (m_mode ? "R7" : "R3"));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule